// File: doc/BRIEF.md
# DMA Linked-List Descriptor Fetcher

This block serves one DMA channel. When the channel's data transfer finishes, it reads the next item of a linked list from memory and loads the channel's working registers from it. A 32-bit link word says which of six registers the next item refreshes. It also gives a 16-bit word-aligned offset, which is joined to a 16-bit upper base to form the item's address.

Only the registers whose enable bits are set are read, one word each, from consecutive word addresses and in a fixed order. Each word returned is presented as a one-cycle load strobe with its data. A link word that is entirely zero in its meaningful bits marks the end of the chain: the block raises a completion pulse and touches nothing. An item that enables no register but has a non-zero offset simply restarts the transfer.

When an item leaves the block-size register out, the block reloads that register from its software-programmed value. A read that returns an error stops the fetch and raises a sticky error flag.

Top module: `llitem_fetch`

## Requirements
- R1: The link word fields are as follows. Bits 15:0 hold the offset, and bits 1:0 of it are ignored. Bits 16 to 21 enable, in that order, control register 1 (index 0), control register 2 (1), block size (2), source address (3), destination address (4) and the link register (5). Bits 31:22 are ignored. When bits 21:16 and bits 15:2 are all zero, `chan_done` pulses for one cycle, in the cycle after `xfer_done` is accepted, and the block issues no read and no load.
- R2: A fetch starts only on `xfer_done` while the block is idle. `xfer_done` during a fetch has no effect.
- R3: The first read goes to byte address {`base_hi`, offset[15:2], 2'b00}. Each later read of the same item goes to the previous address plus 4.
- R4: Only enabled registers are read, in ascending index order. The cycle after each good response, `ld_en` is one-hot at that register's index and `ld_data` equals the response data.
- R5: If an item has some enable bit set but bit 18 (block) clear, `ld_en` equals 6'b000100 with `ld_data` = `blk_prog` in the cycle after acceptance.
- R6: If an item has no enable bit set and a non-zero offset, the block issues no read and no load, and `xfer_start` pulses in the cycle after acceptance.
- R7: After the last load strobe of an item, `xfer_start` pulses for exactly one cycle, in the following cycle.
- R8: The link word is captured at acceptance. Changes on `link_word` during a fetch alter neither the addresses nor the order of the remaining reads.
- R9: An error response produces no load strobe, ends the fetch (`fetch_busy` low in the next cycle), sets `err_flag` and suppresses `xfer_start`.
- R10: `err_flag` stays set until `err_clr` or reset, including across later fetches.
- R11: `rd_req` and `fetch_busy` are high from the first request until the last response. The block has at most one read outstanding, and `rd_addr` is stable while it waits.
- R12: After reset, `fetch_busy`, `rd_req`, `ld_en`, `xfer_start`, `chan_done` and `err_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_done | input | 1 | Current data transfer finished |
| link_word | input | 32 | Link register: update enables and offset |
| base_hi | input | 16 | Upper half of the item address |
| blk_prog | input | 32 | Software-programmed block-size value |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_req | output | 1 | Word read request, held until its response |
| rd_addr | output | 32 | Byte address of the read |
| rsp_valid | input | 1 | Read response present |
| rsp_err | input | 1 | Read response carries an error |
| rsp_data | input | 32 | Read response data |
| ld_en | output | 6 | One-hot register load strobe |
| ld_data | output | 32 | Data for the strobed register |
| xfer_start | output | 1 | Restart the data transfer |
| chan_done | output | 1 | Chain finished |
| fetch_busy | output | 1 | A fetch read is outstanding |
| err_flag | output | 1 | Sticky fetch error |

## Verification
The assertions assume three things about the inputs. Memory gives at most one response per request, and only while `rd_req` is high. `rsp_valid` and `rsp_err` are low during reset. `link_word` and `base_hi` are steady in the cycle `xfer_done` is accepted. The stimulus raises a response only after it has seen the request, holds it for exactly one cycle, and keeps every response input low during reset and between reads. It changes `link_word` and pulses `xfer_done` during a fetch only in cycles where the block is already busy.

// File: rtl/llf_pkg.sv
package llf_pkg;
   // Number of channel registers one list item can refresh
   localparam int NREG = 6;
   // Register indices: this is also the fetch order
   localparam int IDX_CTRL1 = 0;
   localparam int IDX_CTRL2 = 1;
   localparam int IDX_BLK   = 2;
   localparam int IDX_SRC   = 3;
   localparam int IDX_DST   = 4;
   localparam int IDX_LINK  = 5;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_READ = 1'b1
   } llf_state_e;
endpackage

// File: rtl/llf_pick.sv
// Lowest set bit finder: selects the next register to read.
module llf_pick #(
   parameter int N  = 6,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  mask,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end

   assign any = |mask;
endmodule

// File: rtl/llf_addr.sv
// Item read address: loaded from base and offset, stepped by one word.
module llf_addr #(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 16,
   parameter int WORD_BYTES = 4,
   localparam int LSB       = $clog2(WORD_BYTES),
   localparam int BASE_W    = ADDR_W - OFS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [BASE_W-1:0]    base,
   input  logic [OFS_W-LSB-1:0] ofs_word,
   input  logic                 step,
   output logic [ADDR_W-1:0]    addr
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= {base, ofs_word, {LSB{1'b0}}};
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'(WORD_BYTES);
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/llf_sticky.sv
// Sticky flag: set wins over clear.
module llf_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end

   assign flag = flag_q;

   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag); // R10
endmodule

// File: rtl/llitem_fetch.sv
module llitem_fetch
   import llf_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFS_W       = 16,
   parameter int DATA_W      = 32,
   parameter int LINK_W      = 32,
   parameter int MASK_LSB    = 16,
   parameter int WORD_BYTES  = 4,
   parameter bit RESTORE_BLK = 1'b1,
   localparam int BASE_W     = ADDR_W - OFS_W,
   localparam int LSB        = $clog2(WORD_BYTES),
   localparam int IW         = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_done,
   input  logic [LINK_W-1:0] link_word,
   input  logic [BASE_W-1:0] base_hi,
   input  logic [DATA_W-1:0] blk_prog,
   input  logic              err_clr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   input  logic [DATA_W-1:0] rsp_data,
   output logic [NREG-1:0]   ld_en,
   output logic [DATA_W-1:0] ld_data,
   output logic              xfer_start,
   output logic              chan_done,
   output logic              fetch_busy,
   output logic              err_flag
);
   localparam logic [NREG-1:0]   BLK_BIT   = NREG'(1) << IDX_BLK;
   localparam logic [LINK_W-1:0] USED_BITS =
      ((LINK_W'(1) << NREG) - LINK_W'(1)) << MASK_LSB
      | (((LINK_W'(1) << OFS_W) - LINK_W'(1)) & ~((LINK_W'(1) << LSB) - LINK_W'(1)));

   // Elaboration-time parameter checks
   if (OFS_W <= LSB || OFS_W > LINK_W) begin : g_bad_ofs
      $error("llitem_fetch: OFS_W out of range");
   end
   if (MASK_LSB < OFS_W || MASK_LSB + NREG > LINK_W) begin : g_bad_mask
      $error("llitem_fetch: enable field does not fit the link word");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("llitem_fetch: ADDR_W must exceed OFS_W");
   end
   if (WORD_BYTES != (1 << LSB)) begin : g_bad_word
      $error("llitem_fetch: WORD_BYTES must be a power of two");
   end

   // Decode of the link word presented at acceptance
   logic [NREG-1:0]      in_mask;
   logic [OFS_W-LSB-1:0] in_ofs_word;
   logic                 in_end;
   logic                 unused_link;

   assign in_mask     = link_word[MASK_LSB +: NREG];
   assign in_ofs_word = link_word[OFS_W-1:LSB];
   assign in_end      = (in_mask == '0) && (in_ofs_word == '0);
   assign unused_link = ^(link_word & ~USED_BITS);

   // Variant: restore the block register when the item skips it
   logic restore_want;
   if (RESTORE_BLK) begin : g_restore
      assign restore_want = ~in_mask[IDX_BLK];
   end else begin : g_keep
      assign restore_want = 1'b0;
   end

   // State
   llf_state_e        state_q;
   logic [NREG-1:0]   mask_q;
   logic [NREG-1:0]   ld_en_q;
   logic [DATA_W-1:0] ld_data_q;
   logic              start_q;
   logic              start_pend_q;
   logic              done_q;

   logic              accept;
   logic              rsp_ok;
   logic              rsp_bad;
   logic [IW-1:0]     cur_idx;
   logic              cur_any;
   logic [NREG-1:0]   cur_bit;
   logic [NREG-1:0]   rest_mask;

   assign accept    = (state_q == ST_IDLE) && xfer_done;
   assign rsp_ok    = (state_q == ST_READ) && rsp_valid && !rsp_err;
   assign rsp_bad   = (state_q == ST_READ) && rsp_valid && rsp_err;
   assign cur_bit   = NREG'(1) << cur_idx;
   assign rest_mask = mask_q & ~cur_bit;

   llf_pick #(
      .N  (NREG),
      .IW (IW)
   ) u_pick (
      .mask (mask_q),
      .idx  (cur_idx),
      .any  (cur_any)
   );

   llf_addr #(
      .ADDR_W     (ADDR_W),
      .OFS_W      (OFS_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && (in_mask != '0)),
      .base     (base_hi),
      .ofs_word (in_ofs_word),
      .step     (rsp_ok),
      .addr     (rd_addr)
   );

   llf_sticky u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (rsp_bad),
      .clr   (err_clr),
      .flag  (err_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         mask_q       <= '0;
         ld_en_q      <= '0;
         ld_data_q    <= '0;
         start_q      <= 1'b0;
         start_pend_q <= 1'b0;
         done_q       <= 1'b0;
      end else begin
         ld_en_q      <= '0;
         start_q      <= start_pend_q;
         start_pend_q <= 1'b0;
         done_q       <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (in_end) begin
                     done_q <= 1'b1;
                  end else if (in_mask == '0) begin
                     start_q <= 1'b1;
                  end else begin
                     state_q <= ST_READ;
                     mask_q  <= in_mask;
                     if (restore_want) begin
                        ld_en_q   <= BLK_BIT;
                        ld_data_q <= blk_prog;
                     end
                  end
               end
            end
            ST_READ: begin
               if (rsp_bad) begin
                  state_q <= ST_IDLE;
                  mask_q  <= '0;
               end else if (rsp_ok && cur_any) begin
                  ld_en_q   <= cur_bit;
                  ld_data_q <= rsp_data;
                  mask_q    <= rest_mask;
                  if (rest_mask == '0) begin
                     state_q      <= ST_IDLE;
                     start_pend_q <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req     = (state_q == ST_READ);
   assign fetch_busy = (state_q == ST_READ);
   assign ld_en      = ld_en_q;
   assign ld_data    = ld_data_q;
   assign xfer_start = start_q;
   assign chan_done  = done_q;

   // Assertions
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      chan_done |-> !fetch_busy && (ld_en == '0) && !xfer_start); // R1
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_busy && $past(fetch_busy) && $past(rsp_valid)
      |-> rd_addr == $past(rd_addr) + ADDR_W'(WORD_BYTES)); // R3
   AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_en)); // R4
   AST_LD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_en & ~BLK_BIT) != '0) |-> $past(fetch_busy && rsp_valid && !rsp_err)); // R4
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !fetch_busy); // R7
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(rsp_valid && rsp_err) && !xfer_start); // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_busy && $past(fetch_busy) && !$past(rsp_valid) |-> $stable(rd_addr)); // R11
endmodule

// File: tb/llitem_fetch_bench.sv
`timescale 1ns/1ps
module llitem_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_done = 1'b0;
   logic [31:0] link_word = '0;
   logic [15:0] base_hi = '0;
   logic [31:0] blk_prog = 32'h0000_1200;
   logic        err_clr = 1'b0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rsp_valid = 1'b0;
   logic        rsp_err = 1'b0;
   logic [31:0] rsp_data = '0;
   logic [5:0]  ld_en;
   logic [31:0] ld_data;
   logic        xfer_start;
   logic        chan_done;
   logic        fetch_busy;
   logic        err_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   llitem_fetch u_llitem_fetch (
      .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .link_word(link_word),
      .base_hi(base_hi), .blk_prog(blk_prog), .err_clr(err_clr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_data(rsp_data), .ld_en(ld_en), .ld_data(ld_data),
      .xfer_start(xfer_start), .chan_done(chan_done), .fetch_busy(fetch_busy),
      .err_flag(err_flag)
   );

   // {link word, upper base}
   localparam logic [47:0] VEC [6] = '{
      {32'h003F_0010, 16'h2000},   // all six registers
      {32'h0001_0104, 16'h4000},   // control 1 only, block restored
      {32'h0014_0ABF, 16'h1234},   // block and destination, offset low bits ignored
      {32'h0029_FFFC, 16'hFFFF},   // control 1, source, link
      {32'hFFC0_0040, 16'h0800},   // no enables, non-zero offset
      {32'hFFC0_0003, 16'h0800}    // end of chain
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_item(input logic [31:0] lw, input logic [15:0] bh, input int err_at);
      logic [5:0]  m;
      logic [31:0] a;
      logic [31:0] d;
      int          k;
      m = lw[21:16];
      a = {bh, lw[15:2], 2'b00};
      k = 0;
      @(negedge clk);
      link_word = lw; base_hi = bh; xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      if (m == 6'd0 && lw[15:2] == 14'd0) begin
         chk(chan_done == 1'b1, "R1 done pulse", 32'(chan_done), 32'd1);
         chk(!fetch_busy && !xfer_start && ld_en == 6'd0, "R1 quiet",
             {ld_en, xfer_start, fetch_busy}, 32'd0);
         @(negedge clk);
         chk(chan_done == 1'b0 && !rd_req, "R1 one cycle", 32'(chan_done), 32'd0);
         return;
      end
      if (m == 6'd0) begin
         chk(xfer_start && !fetch_busy && ld_en == 6'd0, "R6 restart",
             {ld_en, xfer_start, fetch_busy}, {6'd0, 1'b1, 1'b0});
         @(negedge clk);
         chk(!xfer_start && !rd_req && ld_en == 6'd0, "R6 no read", 32'(rd_req), 32'd0);
         return;
      end
      chk(fetch_busy && rd_req, "R11 busy at first request", 32'(fetch_busy), 32'd1);
      if (!m[2]) chk(ld_en == 6'b000100 && ld_data == blk_prog, "R5 block restore",
                     ld_data, blk_prog);
      else       chk(ld_en == 6'd0, "R5 no restore", 32'(ld_en), 32'd0);
      for (int i = 0; i < 6; i++) begin
         if (m[i]) begin
            chk(rd_addr == a && rd_req, "R3 read address", rd_addr, a);
            if (k == 0) begin
               xfer_done = 1'b1;
               link_word = 32'h0000_0000;
            end
            @(negedge clk);
            xfer_done = 1'b0;
            chk(rd_req && rd_addr == a && ld_en == 6'd0, "R11 waiting", rd_addr, a);
            chk(!chan_done, "R2 done ignored in fetch", 32'(chan_done), 32'd0);
            d = a ^ 32'h5A00_0000 ^ (32'(i) << 24);
            rsp_valid = 1'b1; rsp_data = d; rsp_err = (k == err_at);
            @(negedge clk);
            rsp_valid = 1'b0; rsp_err = 1'b0;
            if (k == err_at) begin
               chk(ld_en == 6'd0, "R9 no load on error", 32'(ld_en), 32'd0);
               chk(!fetch_busy && err_flag, "R9 stop and flag", {fetch_busy, err_flag}, 32'd1);
               @(negedge clk);
               chk(!xfer_start && !rd_req, "R9 no restart", 32'(xfer_start), 32'd0);
               return;
            end
            chk(ld_en == (6'd1 << i) && ld_data == d, "R4 load strobe",
                {ld_en, ld_data[25:0]}, {6'd1 << i, d[25:0]});
            if (k > 0) chk(ld_data == d, "R8 captured link kept", ld_data, d);
            a = a + 32'd4;
            k++;
         end
      end
      chk(!fetch_busy && !rd_req && !xfer_start, "R11 busy ends", 32'(fetch_busy), 32'd0);
      @(negedge clk);
      chk(xfer_start && ld_en == 6'd0, "R7 start after last load", 32'(xfer_start), 32'd1);
      @(negedge clk);
      chk(!xfer_start, "R7 single pulse", 32'(xfer_start), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!fetch_busy && !rd_req && ld_en == 6'd0 && !xfer_start && !chan_done && !err_flag,
          "R12 reset state", {ld_en, fetch_busy, rd_req, xfer_start, chan_done, err_flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!fetch_busy && !err_flag && !xfer_start, "R12 after release",
          {fetch_busy, err_flag, xfer_start}, 32'd0);

      for (int v = 0; v < 6; v++) run_item(VEC[v][47:16], VEC[v][15:0], -1);

      // Error on the second read of a three-register item
      run_item(32'h0007_0200, 16'h3000, 1);
      // Error flag survives a good fetch
      run_item(32'h0010_0020, 16'h3100, -1);
      chk(err_flag, "R10 sticky across fetch", 32'(err_flag), 32'd1);
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(!err_flag, "R10 cleared", 32'(err_flag), 32'd0);
      // End of chain after error cleared
      run_item(32'h0000_0000, 16'h0000, -1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run hung, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule